// File: doc/BRIEF.md
# Watchdog Reset Supervisor

This block watches a processor's activity strobe and pulls a system reset when the processor stops showing signs of life. The processor is expected to toggle the strobe regularly. Any change of its level, rising or falling, restarts a timeout counter. If the counter runs for a full timeout interval without seeing a change, the block raises its reset output. That output then stays high for a guaranteed minimum number of clock cycles.

The strobe arrives asynchronously. It passes through a flop synchronizer and an edge detector before it reaches the counter. The sampling clock has to be faster than the shortest strobe pulse the processor can emit, so that both edges of a narrow pulse are seen. A digital power-good input overrides everything else. While it is low, reset is held high, and the minimum pulse width is counted again from the moment it returns. The counter is held at zero for the whole time reset is high and starts counting only once reset drops.

Both the timeout and the reset pulse width are parameters given in clock cycles.

Top module: `wdog_supervisor`

## Requirements
- R1: While `pwrGood` is low, `sysReset` is 1. It rises as soon as `pwrGood` falls, without waiting for a clock edge, and this includes start-up.
- R2: After `pwrGood` returns high, `sysReset` stays 1 for exactly PULSE_CYCLES clock cycles and then goes to 0.
- R3: If the strobe does not change level, `sysReset` returns to 1 exactly TIMEOUT_CYCLES cycles after it fell.
- R4: A rising or a falling change of `wdStrobe` restarts the timeout. The change lands at the counter on the third rising clock edge after it (two synchronizer flops plus one edge-detect flop). With no further change, `sysReset` rises TIMEOUT_CYCLES cycles after that edge.
- R5: A strobe change that reaches the counter on the same edge on which the timeout would expire wins, and no reset is produced.
- R6: Strobe changes that arrive while `sysReset` is 1 have no effect. The counter holds at zero during reset and starts from zero in the cycle after reset falls, so the next reset comes exactly TIMEOUT_CYCLES cycles later.
- R7: A strobe pulse only one clock period wide is seen as two separate changes. The later change sets the restart point.
- R8: A reset caused by a timeout also lasts exactly PULSE_CYCLES cycles. If `pwrGood` drops during any reset pulse, the full width is counted again after it returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; its period must be shorter than the narrowest strobe pulse |
| pwrGood | input | 1 | Supply-valid indication, active high; low forces and holds reset and clears all state |
| wdStrobe | input | 1 | Asynchronous processor activity strobe; either edge restarts the timeout |
| sysReset | output | 1 | System reset, active high, registered |

## Verification
The bench sweeps the point at which the strobe toggles across the whole timeout window, one cycle at a time.

- Near the end of the window, a design with the wrong synchronizer latency, or one that lets expiry beat a same-cycle edge, produces a low phase one cycle off or an extra reset.
- Toggles placed so that their edge lands inside the reset pulse catch a counter that keeps running, or picks up a stale edge, during reset. That design shortens the low phase that follows.
- One-cycle pulses show whether the falling edge is lost.
- Drops of `pwrGood`, both in the running phase and inside a pulse, expose a reset that waits for a clock edge or a pulse width that is not counted afresh.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // control -> datapath
  typedef struct packed {
    logic holdClear;   // keep the timeout counter at zero
  } ctlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic expired;     // timeout reached with no strobe edge this cycle
  } dpStrobes_t;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } supState_t;

endpackage

// File: rtl/wdog_strobe_sync.sv
module wdog_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pwrGood,
  input  logic strobeAsync,
  output logic edgePulse
);
  // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) chain[0] <= 1'b0;
    else          chain[0] <= strobeAsync;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge pwrGood) begin
      if (!pwrGood) chain[i] <= 1'b0;
      else          chain[i] <= chain[i-1];
    end
  end

  assign edgePulse = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/wdog_timer_dp.sv
module wdog_timer_dp
  import wdog_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 80_000_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic        clk,
  input  logic        pwrGood,
  input  logic        strobeAsync,
  input  ctlStrobes_t ctlIn,
  output dpStrobes_t  dpOut
);
  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(TIMEOUT_CYCLES - 1);

  logic             edgePulse;
  logic [CNT_W-1:0] toCnt;
  logic             expiredNow;

  wdog_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk         (clk),
    .pwrGood     (pwrGood),
    .strobeAsync (strobeAsync),
    .edgePulse   (edgePulse)
  );

  // an edge arriving in the last cycle takes priority over expiry
  assign expiredNow = !ctlIn.holdClear && !edgePulse && (toCnt == LAST_COUNT);

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood)                                        toCnt <= '0;
    else if (ctlIn.holdClear || edgePulse || expiredNow) toCnt <= '0;
    else                                                 toCnt <= toCnt + 1'b1;
  end

  assign dpOut.expired = expiredNow;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!pwrGood)
    toCnt <= LAST_COUNT);

  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!pwrGood)
    ctlIn.holdClear |=> toCnt == '0);

  a_r4_edge_restart: assert property (@(posedge clk) disable iff (!pwrGood)
    edgePulse |=> toCnt == '0);

endmodule

// File: rtl/wdog_reset_ctl.sv
module wdog_reset_ctl
  import wdog_pkg::*;
#(
  parameter int PULSE_CYCLES = 10_000_000
) (
  input  logic        clk,
  input  logic        pwrGood,
  input  dpStrobes_t  dpIn,
  output ctlStrobes_t ctlOut,
  output logic        resetOut
);
  localparam int PW_W = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [PW_W-1:0] LAST_PULSE = PW_W'(PULSE_CYCLES - 1);

  supState_t        state;
  logic [PW_W-1:0]  pulseCnt;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      state    <= ST_HOLD;
      pulseCnt <= '0;
    end else begin
      unique case (state)
        ST_HOLD: begin
          if (pulseCnt == LAST_PULSE) begin
            state    <= ST_RUN;
            pulseCnt <= '0;
          end else begin
            pulseCnt <= pulseCnt + 1'b1;
          end
        end
        ST_RUN: begin
          pulseCnt <= '0;
          if (dpIn.expired) state <= ST_HOLD;
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  assign ctlOut.holdClear = (state == ST_HOLD);
  assign resetOut         = (state == ST_HOLD);

  a_r3_expiry_asserts: assert property (@(posedge clk) disable iff (!pwrGood)
    (state == ST_RUN && dpIn.expired) |=> resetOut);

  a_r2_full_width: assert property (@(posedge clk) disable iff (!pwrGood)
    $fell(resetOut) |-> $past(pulseCnt) == LAST_PULSE);

  a_r8_no_glitch: assert property (@(posedge clk) disable iff (!pwrGood)
    $rose(resetOut) |=> resetOut);

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 80_000_000,
  parameter int PULSE_CYCLES   = 10_000_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic pwrGood,
  input  logic wdStrobe,
  output logic sysReset
);
  ctlStrobes_t ctlBus;
  dpStrobes_t  dpBus;

  wdog_timer_dp #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .SYNC_STAGES    (SYNC_STAGES)
  ) dp_i (
    .clk         (clk),
    .pwrGood     (pwrGood),
    .strobeAsync (wdStrobe),
    .ctlIn       (ctlBus),
    .dpOut       (dpBus)
  );

  wdog_reset_ctl #(
    .PULSE_CYCLES (PULSE_CYCLES)
  ) ctl_i (
    .clk      (clk),
    .pwrGood  (pwrGood),
    .dpIn     (dpBus),
    .ctlOut   (ctlBus),
    .resetOut (sysReset)
  );

endmodule

// File: tb/wdog_supervisor_tb.sv
`timescale 1ns/1ps
module wdog_supervisor_tb_top;
  localparam int TO = 16;
  localparam int PW = 5;
  localparam int LAT = 3;   // two sync flops + edge register

  logic clk = 1'b0;
  logic pwrGood = 1'b0;
  logic wdStrobe = 1'b0;
  logic sysReset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  wdog_supervisor #(
    .TIMEOUT_CYCLES (TO),
    .PULSE_CYCLES   (PW),
    .SYNC_STAGES    (2)
  ) dut_i (
    .clk      (clk),
    .pwrGood  (pwrGood),
    .wdStrobe (wdStrobe),
    .sysReset (sysReset)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge where sysReset was just seen high; counts high samples
  task automatic countHigh(output int m);
    m = 1;
    forever begin
      @(negedge clk);
      if (sysReset) m++;
      else break;
    end
  endtask

  // called at the first low sample; toggles the strobe at low sample index g
  // (and g+1 when pulse is set); g < 0 means no toggle
  task automatic countLow(input int g, input bit pulse, output int n);
    n = 1;
    if (g == 0) wdStrobe = ~wdStrobe;
    forever begin
      @(negedge clk);
      if (!sysReset) begin
        if (n == g || (pulse && n == g + 1)) wdStrobe = ~wdStrobe;
        n++;
      end else break;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int n;
    int m;
    int exp;
    // R1: held in reset from start-up
    repeat (3) begin
      @(negedge clk);
      check(sysReset == 1'b1, "R1 power-on", int'(sysReset), 1);
    end
    // R2: release
    pwrGood = 1'b1;
    #1;
    check(sysReset == 1'b1, "R2 release sample", int'(sysReset), 1);
    countHigh(m);
    check(m == PW, "R2 pulse after power-good", m, PW);

    // R3: free-running timeout
    countLow(-1, 1'b0, n);
    check(n == TO, "R3 no strobe", n, TO);
    countHigh(m);
    check(m == PW, "R8 timeout pulse width", m, PW);

    // R4/R5/R6: single edge swept over the window, both polarities
    for (int g = 0; g <= TO + 1; g++) begin
      exp = (g + LAT <= TO) ? g + LAT + TO : TO;
      countLow(g, 1'b0, n);
      if (g + LAT == TO) check(n == exp, "R5 edge at expiry", n, exp);
      else if (g + LAT > TO) check(n == exp, "R6 late edge", n, exp);
      else check(n == exp, "R4 edge restart", n, exp);
      countHigh(m);
      check(m == PW, "R8 pulse width", m, PW);
    end

    // R6: counting restarts from zero after the pulse
    countLow(-1, 1'b0, n);
    check(n == TO, "R6 clean window after pulse", n, TO);
    countHigh(m);

    // R7: one-cycle strobe pulses
    for (int g = 0; g <= TO - 2; g++) begin
      exp = (g + LAT <= TO) ? g + LAT + 1 + TO : TO;
      countLow(g, 1'b1, n);
      check(n == exp, "R7 narrow pulse", n, exp);
      countHigh(m);
      check(m == PW, "R8 pulse width", m, PW);
    end

    // R1: power-good drop while running
    repeat (4) @(negedge clk);
    check(sysReset == 1'b0, "R3 running before drop", int'(sysReset), 0);
    pwrGood = 1'b0;
    #1;
    check(sysReset == 1'b1, "R1 immediate assert", int'(sysReset), 1);
    repeat (4) begin
      @(negedge clk);
      check(sysReset == 1'b1, "R1 held while low", int'(sysReset), 1);
    end
    pwrGood = 1'b1;
    #1;
    countHigh(m);
    check(m == PW, "R2 pulse after drop", m, PW);
    countLow(-1, 1'b0, n);
    check(n == TO, "R6 window after power-good", n, TO);

    // R8: drop inside a timeout pulse restarts the width
    @(negedge clk);
    pwrGood = 1'b0;
    repeat (3) @(negedge clk);
    check(sysReset == 1'b1, "R8 held during drop", int'(sysReset), 1);
    pwrGood = 1'b1;
    #1;
    countHigh(m);
    check(m == PW, "R8 width restarted", m, PW);
    countLow(-1, 1'b0, n);
    check(n == TO, "R3 final window", n, TO);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule